// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Controller

This block watches a port of general-purpose input pins and raises one interrupt line when any enabled pin has an event pending. Each pin is configured on its own to sense either a level or an edge, and either the low/falling or the high/rising direction. Edge events are held in a per-pin latch until software acknowledges them. Level events are never held: they track the pin for as long as it stays at the active level.

Software reaches the block through a small byte-wide register bus with four word slots: sense mode, polarity, acknowledge and enable. The enabled pending pins can be read back, and a raw vector of every pending pin, ignoring the enable mask, is driven out as a port. Hardware does not detect both edges. Software does this by setting the polarity opposite to the current pin level and inverting it after each acknowledge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Slot 0 (bus_addr = 0) holds the sense mode, one bit per pin at the pin's index. A bit value of 0 selects level sensing and 1 selects edge sensing.
- R2: Slot 1 holds the polarity, one bit per pin. A bit value of 0 selects low level or falling edge, and 1 selects high level or rising edge.
- R3: Writing slot 2 clears the edge latch of every pin whose data bit is 1 and leaves the other latches untouched. An edge arriving in the same cycle as the acknowledge stays latched.
- R4: Slot 3 holds the enable mask. irq_o is the OR over all pins of (pending AND enabled).
- R5: A read of slot 2 returns the pending pins ANDed with the enable mask. irq_raw shows every pending pin whatever the mask.
- R6: An edge that arrives while its pin's enable bit is 0 is not recorded, and it does not appear after the pin is enabled again.
- R7: A pin in level mode is pending exactly while its synchronised input equals its polarity bit. Acknowledge writes have no effect on it.
- R8: A write to slot 0 or slot 1 clears the edge latch only of the pins whose bit changes value.
- R9: After a pin input change, level status shows on irq_raw after 2 rising clock edges and a latched edge after 3.
- R10: After reset, mode, polarity and enable read 0 and irq_o is 0. With all pins low, irq_raw is all ones, because every pin is in low-level mode.
- R11: Both-edge operation works by toggling the polarity. After a rising edge is latched, acknowledged and the polarity bit inverted, the following falling edge on that pin is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 8 | Asynchronous pin inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word slot: 0 mode, 1 polarity, 2 acknowledge/status, 3 enable |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Read data for the addressed slot (combinational) |
| irq_raw | output | 8 | Pending pins, enable mask not applied |
| irq_o | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the clock edge that ends the write cycle, so the bench checks read-back and acknowledge results at the falling edge that follows. A pin change passes two synchroniser flops, so level status is due after two rising edges. An edge latch takes a third edge. The latency scenario samples at the falling edge after the second rising edge and expects no edge yet, then samples again after the third. All other scenarios drive pins and bus at falling edges and wait at least four cycles before sampling, so every result has settled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SLOT_MODE = 2'd0,
    SLOT_POL  = 2'd1,
    SLOT_ACK  = 2'd2,
    SLOT_EN   = 2'd3
  } slot_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_now,
  output logic [NPINS-1:0] pin_prev
);
  logic [NPINS-1:0] meta_q, now_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  assign pin_now  = now_q;
  assign pin_prev = prev_q;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_now,
  input  logic pin_prev,
  input  logic mode_edge,
  input  logic pol_high,
  input  logic enable,
  input  logic ack,
  input  logic cfg_chg,
  output logic pending
);
  logic latch_q, latch_d;
  logic rise, fall, hit, set_evt, level_hit;

  always_comb begin
    rise      = pin_now & ~pin_prev;
    fall      = ~pin_now & pin_prev;
    hit       = pol_high ? rise : fall;
    set_evt   = mode_edge & enable & hit & ~cfg_chg;
    level_hit = ~mode_edge & ~(pin_now ^ pol_high);
    if (cfg_chg) latch_d = 1'b0;
    else         latch_d = (latch_q & ~ack) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end

  assign pending = level_hit | latch_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_evt) |=> !latch_q); // R3
  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !latch_q) |=> !latch_q); // R6
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_edge && !cfg_chg) |=> (!mode_edge -> !latch_q)); // R7
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !latch_q); // R8
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic [NPINS-1:0] status_masked,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS-1:0] mode_q,
  output logic [NPINS-1:0] pol_q,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] ack_pulse,
  output logic [NPINS-1:0] cfg_chg
);
  slot_e            slot;
  logic             wr_mode, wr_pol, wr_ack, wr_en;
  logic [NPINS-1:0] mode_d, pol_d, en_d;

  always_comb begin
    slot    = slot_e'(bus_addr);
    wr_mode = bus_sel & bus_wr & (slot == SLOT_MODE);
    wr_pol  = bus_sel & bus_wr & (slot == SLOT_POL);
    wr_ack  = bus_sel & bus_wr & (slot == SLOT_ACK);
    wr_en   = bus_sel & bus_wr & (slot == SLOT_EN);
    mode_d  = wr_mode ? bus_wdata : mode_q;
    pol_d   = wr_pol  ? bus_wdata : pol_q;
    en_d    = wr_en   ? bus_wdata : en_q;
    ack_pulse = wr_ack ? bus_wdata : '0;
    cfg_chg   = (wr_mode ? (mode_q ^ bus_wdata) : '0)
              | (wr_pol  ? (pol_q  ^ bus_wdata) : '0);
    case (slot)
      SLOT_MODE: bus_rdata = mode_q;
      SLOT_POL:  bus_rdata = pol_q;
      SLOT_ACK:  bus_rdata = status_masked;
      default:   bus_rdata = en_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
    end
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(bus_wdata))); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q)); // R1
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pol |=> $stable(pol_q)); // R2
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS-1:0] irq_raw,
  output logic             irq_o
);
  logic [1:0]       rst_q;
  logic             rst_int_n;
  logic [NPINS-1:0] pin_now, pin_prev;
  logic [NPINS-1:0] mode_q, pol_q, en_q, ack_pulse, cfg_chg;
  logic [NPINS-1:0] pending, status_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  gpio_irq_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in),
    .pin_now(pin_now), .pin_prev(pin_prev)
  );

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_masked(status_masked),
    .bus_rdata(bus_rdata), .mode_q(mode_q), .pol_q(pol_q), .en_q(en_q),
    .ack_pulse(ack_pulse), .cfg_chg(cfg_chg)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk(clk), .rst_n(rst_int_n),
      .pin_now(pin_now[i]), .pin_prev(pin_prev[i]),
      .mode_edge(mode_q[i]), .pol_high(pol_q[i]), .enable(en_q[i]),
      .ack(ack_pulse[i]), .cfg_chg(cfg_chg[i]),
      .pending(pending[i])
    );
  end

  assign status_masked = pending & en_q;
  assign irq_raw       = pending;
  assign irq_o         = |status_masked;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_q == '0) |-> !irq_o); // R4
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_raw == '0) |-> !irq_o); // R5
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, irq_raw;
  logic       irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(8)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_raw(irq_raw), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic clean();
    wr(3, 8'h00); wr(0, 8'hFF); wr(1, 8'hFF);
    set_pins(8'h00); wait_cyc(4); wr(2, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R10 irq_o", {7'b0, irq_o}, 8'h00);
    chk("R10 irq_raw", irq_raw, 8'hFF);
    rd(0, d); chk("R10 mode", d, 8'h00);
    rd(1, d); chk("R10 pol", d, 8'h00);
    rd(3, d); chk("R10 enable", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    clean();
    wr(0, 8'h00); wr(3, 8'hFF);
    wait_cyc(1);
    chk("R1 level idle raw", irq_raw, 8'h00);
    set_pins(8'h05); wait_cyc(4);
    chk("R2 level high raw", irq_raw, 8'h05);
    rd(2, d); chk("R5 status read", d, 8'h05);
    chk("R4 irq asserted", {7'b0, irq_o}, 8'h01);
    wr(2, 8'hFF);
    chk("R7 ack no effect on level", irq_raw, 8'h05);
    set_pins(8'h00); wait_cyc(4);
    chk("R7 level follows pin", irq_raw, 8'h00);
    wr(1, 8'hFE); wait_cyc(1);
    chk("R2 low level active", irq_raw, 8'h01);
  endtask

  task automatic t_latency();
    clean(); wr(3, 8'hFF);
    set_pins(8'h08); wait_cyc(2);
    chk("R9 edge not yet at 2", irq_raw, 8'h00);
    wait_cyc(1);
    chk("R9 edge at 3", irq_raw, 8'h08);
    set_pins(8'h00); wait_cyc(4);
    chk("R1 edge stays latched", irq_raw, 8'h08);
    wr(2, 8'h00);
    chk("R3 ack zero keeps latch", irq_raw, 8'h08);
    wr(2, 8'h08);
    chk("R3 ack clears latch", irq_raw, 8'h00);
    wr(0, 8'h00); wr(1, 8'hFF);
    set_pins(8'h02); wait_cyc(2);
    chk("R9 level at 2", irq_raw, 8'h02);
  endtask

  task automatic t_falling();
    clean(); wr(3, 8'hFF); wr(1, 8'hFD);
    set_pins(8'h02); wait_cyc(4);
    chk("R2 rising ignored on falling pin", irq_raw, 8'h00);
    set_pins(8'h00); wait_cyc(4);
    chk("R2 falling latched", irq_raw, 8'h02);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    clean(); wr(3, 8'h0F);
    set_pins(8'hF0); wait_cyc(4);
    wr(3, 8'hFF);
    chk("R6 disabled edge not recorded", irq_raw, 8'h00);
    set_pins(8'hF1); wait_cyc(4);
    chk("R4 enabled edge", irq_raw, 8'h01);
    wr(3, 8'h00);
    chk("R4 irq masked", {7'b0, irq_o}, 8'h00);
    rd(2, d); chk("R5 masked status", d, 8'h00);
    chk("R5 raw ignores mask", irq_raw, 8'h01);
    wr(3, 8'h01);
    chk("R4 irq back", {7'b0, irq_o}, 8'h01);
  endtask

  task automatic t_cfg();
    clean(); wr(3, 8'hFF);
    set_pins(8'h05); wait_cyc(4);
    chk("R8 two latched", irq_raw, 8'h05);
    wr(1, 8'hFE);
    chk("R8 only changed pin cleared", irq_raw, 8'h04);
  endtask

  task automatic t_both();
    clean(); wr(3, 8'hFF);
    set_pins(8'h20); wait_cyc(4);
    chk("R11 rising caught", irq_raw, 8'h20);
    wr(2, 8'h20); wr(1, 8'hDF);
    chk("R11 cleared after flip", irq_raw, 8'h00);
    set_pins(8'h00); wait_cyc(4);
    chk("R11 falling caught", irq_raw, 8'h20);
  endtask

  initial begin
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_level();
    t_latency();
    t_falling();
    t_mask();
    t_cfg();
    t_both();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule